// File: doc/BRIEF.md
# Masked Two-Field Segment Load Unpacker

This block distributes a stream of 16-bit memory elements, arriving as interleaved pairs, into two destination register images. Each pair is one segment. Its first field goes to the first destination and its second field goes to the second destination, in the slot equal to the segment number. A start pulse captures the prior contents of both destinations, the per-slot mask and the active length. The block then takes one 32-bit segment word per cycle, for segment numbers counting up from zero.

A slot is written only when its mask bit is 1 and its number is below the active length. Every other slot keeps the value it held when the operation started, in both destinations. Both images appear on the outputs, and a one-cycle done strobe marks the end of the operation.

Top module: `seg2_unpack`

## Requirements
- R1: After reset, busy, done and seg_idx are 0, and both destination outputs are all zeros.
- R2: For a slot i whose mask bit is 1 and where i < length, bits [15:0] of the segment word are written to slot i of dest0_out. Bits [31:16] of the same word are written to slot i of dest1_out. Slot i occupies bits [16*i+15:16*i].
- R3: A slot whose mask bit is 0 keeps its captured value in both outputs.
- R4: Slots at or beyond the length keep their captured values, whatever their mask bits are.
- R5: After an accepted start, seg_idx presents 0, 1, ... up to length-1, one per cycle, while busy is 1. done is 1 for exactly one cycle, at the edge that writes the last segment.
- R6: A length of 0 writes nothing, and done rises at the edge that accepts start.
- R7: A start pulse that arrives while busy is 1 is ignored and does not disturb the running operation.
- R8: A length above the slot count is treated as the slot count.
- R9: Consider length 6, with only mask bit 5 set, destinations preloaded with 0x1111 and 0x2222, and segment 5 holding 0x1005 and 0x2005. The result has slot 5 equal to 0x1005 and 0x2005, and every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| vlen | input | 4 | Active length, captured on start |
| mask | input | 8 | Per-slot write enable, captured on start |
| dest0_in | input | 128 | Prior contents of the first destination |
| dest1_in | input | 128 | Prior contents of the second destination |
| seg_word | input | 32 | Segment word for seg_idx: field 0 low, field 1 high |
| seg_idx | output | 3 | Segment number currently consumed |
| dest0_out | output | 128 | First destination image |
| dest1_out | output | 128 | Second destination image |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end strobe |

## Verification
A new start can arrive in the same cycle in which the block is writing a segment. The bench provokes this by raising start in the middle of a long operation, with a full mask and a different preload. The final images must still match the model of the first operation alone, and done must arrive on its expected cycle. The final write and the done strobe also share a cycle, and this is judged by counting cycles from start against the clamped length.

// File: rtl/seg2_unpack.sv
module seg2_unpack #(
  parameter int NSLOT = 8,
  parameter int EW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [$clog2(NSLOT+1)-1:0] vlen,
  input  logic [NSLOT-1:0]      mask,
  input  logic [NSLOT*EW-1:0]   dest0_in,
  input  logic [NSLOT*EW-1:0]   dest1_in,
  input  logic [2*EW-1:0]       seg_word,
  output logic [$clog2(NSLOT)-1:0] seg_idx,
  output logic [NSLOT*EW-1:0]   dest0_out,
  output logic [NSLOT*EW-1:0]   dest1_out,
  output logic                  busy,
  output logic                  done
);
  localparam int IW = $clog2(NSLOT);
  localparam int VW = $clog2(NSLOT+1);

  logic [NSLOT-1:0][EW-1:0] d0_q, d1_q;
  logic [NSLOT-1:0]         mask_q;
  logic [VW-1:0]            vl_q;
  logic [IW-1:0]            idx_q;
  logic                     busy_q, done_q;

  logic [VW-1:0] vl_eff;
  logic          last;

  assign vl_eff = (vlen > VW'(NSLOT)) ? VW'(NSLOT) : vlen;
  assign last   = (VW'(idx_q) == vl_q - VW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d0_q   <= '0;
      d1_q   <= '0;
      mask_q <= '0;
      vl_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        d0_q   <= dest0_in;
        d1_q   <= dest1_in;
        mask_q <= mask;
        vl_q   <= vl_eff;
        idx_q  <= '0;
        busy_q <= (vl_eff != '0);
        done_q <= (vl_eff == '0);
      end else if (busy_q) begin
        if (mask_q[idx_q]) begin
          d0_q[idx_q] <= seg_word[EW-1:0];
          d1_q[idx_q] <= seg_word[2*EW-1:EW];
        end
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end

  assign seg_idx   = idx_q;
  assign dest0_out = d0_q;
  assign dest1_out = d1_q;
  assign busy      = busy_q;
  assign done      = done_q;
endmodule

// File: rtl/seg2_unpack_chk.sv
module seg2_unpack_chk #(
  parameter int NSLOT = 8,
  parameter int EW    = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic [$clog2(NSLOT+1)-1:0] vlen,
  input logic [NSLOT-1:0]      mask_q,
  input logic [2*EW-1:0]       seg_word,
  input logic [$clog2(NSLOT)-1:0] seg_idx,
  input logic [NSLOT*EW-1:0]   dest0_out,
  input logic [NSLOT*EW-1:0]   dest1_out,
  input logic                  busy,
  input logic                  done
);
  localparam int IW = $clog2(NSLOT);

  a_r2_field_write: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mask_q[seg_idx] |=>
      dest0_out[$past(seg_idx)*EW +: EW] == $past(seg_word[EW-1:0]) &&
      dest1_out[$past(seg_idx)*EW +: EW] == $past(seg_word[2*EW-1:EW]));

  a_r3_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mask_q[seg_idx] |=> $stable(dest0_out) && $stable(dest1_out));

  a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy || seg_idx == $past(seg_idx) + IW'(1));

  a_r5_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && vlen == '0 |=> done && !busy);

  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy && mask_q[seg_idx] == 1'b0 |=> $stable(dest0_out));
endmodule

bind seg2_unpack seg2_unpack_chk #(.NSLOT(NSLOT), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .mask_q(mask_q),
  .seg_word(seg_word), .seg_idx(seg_idx), .dest0_out(dest0_out),
  .dest1_out(dest1_out), .busy(busy), .done(done)
);

// File: tb/sim_seg2_unpack.sv
module sim_seg2_unpack;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] vlen = '0;
  logic [N-1:0] mask = '0;
  logic [N*16-1:0] dest0_in = '0, dest1_in = '0;
  logic [31:0] seg_word;
  logic [2:0] seg_idx;
  logic [N*16-1:0] dest0_out, dest1_out;
  logic busy, done;
  logic [15:0] seg0 [N];
  logic [15:0] seg1 [N];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  assign seg_word = {seg1[seg_idx], seg0[seg_idx]};

  seg2_unpack u0 (.clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .mask(mask),
    .dest0_in(dest0_in), .dest1_in(dest1_in), .seg_word(seg_word), .seg_idx(seg_idx),
    .dest0_out(dest0_out), .dest1_out(dest1_out), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff_len(input logic [3:0] v);
    return (v > N) ? N : int'(v);
  endfunction

  function automatic logic [15:0] model(input int i, input int vl, input logic [N-1:0] m,
                                        input logic [15:0] pre, input logic [15:0] seg);
    return (i < vl && m[i]) ? seg : pre;
  endfunction

  task automatic run_op(input logic [3:0] v, input logic [N-1:0] m,
                        input logic [N*16-1:0] a0, input logic [N*16-1:0] a1, input bit poke);
    int vl = eff_len(v);
    int k = 0;
    start = 1'b1; vlen = v; mask = m; dest0_in = a0; dest1_in = a1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    while (!done && k < 20) begin
      if (busy) chk(seg_idx == 3'(k), "R5 seg_idx", longint'(seg_idx), longint'(k));
      if (poke && k == 1) begin
        start = 1'b1; vlen = 4'd8; mask = '1; dest0_in = ~a0; dest1_in = ~a1;
      end
      @(posedge clk); @(negedge clk);
      start = 1'b0; dest0_in = a0; dest1_in = a1;
      k++;
    end
    chk(done && k == vl, (vl == 0) ? "R6 done timing" : (poke ? "R7 done timing" : "R5 done timing"),
        longint'(k), longint'(vl));
    for (int i = 0; i < N; i++) begin
      logic [15:0] e0 = model(i, vl, m, a0[i*16 +: 16], seg0[i]);
      logic [15:0] e1 = model(i, vl, m, a1[i*16 +: 16], seg1[i]);
      string tag = poke ? "R7 slot" : (i >= vl ? "R4 slot" : (m[i] ? "R2 slot" : "R3 slot"));
      chk(dest0_out[i*16 +: 16] == e0 && dest1_out[i*16 +: 16] == e1, tag,
          longint'({dest1_out[i*16 +: 16], dest0_out[i*16 +: 16]}), longint'({e1, e0}));
    end
    @(posedge clk); @(negedge clk);
    chk(!done && !busy, "R5 single done", longint'(done), 0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [N*16-1:0] a0, a1;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin seg0[i] = 16'(i); seg1[i] = 16'(i); end
    #35;
    chk(!busy && !done && seg_idx == 0 && dest0_out == '0 && dest1_out == '0, "R1 reset",
        longint'({busy, done}), 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", longint'({busy, done}), 0);

    for (int i = 0; i < N; i++) begin
      seg0[i] = 16'h1000 + 16'(i); seg1[i] = 16'h2000 + 16'(i);
    end
    run_op(4'd6, 8'h20, {N{16'h1111}}, {N{16'h2222}}, 1'b0);
    chk(dest0_out[5*16 +: 16] == 16'h1005 && dest1_out[5*16 +: 16] == 16'h2005, "R9 lane5",
        longint'({dest1_out[95:80], dest0_out[95:80]}), 32'h2005_1005);
    chk(dest0_out[4*16 +: 16] == 16'h1111 && dest1_out[6*16 +: 16] == 16'h2222, "R9 neighbours",
        longint'({dest1_out[111:96], dest0_out[79:64]}), 32'h2222_1111);

    run_op(4'd0, 8'hFF, {N{16'hAAAA}}, {N{16'h5555}}, 1'b0);
    chk(dest0_out == {N{16'hAAAA}}, "R6 no writes", longint'(dest0_out[15:0]), 16'hAAAA);
    run_op(4'd15, 8'hFF, {N{16'h0}}, {N{16'h0}}, 1'b0);
    chk(dest0_out[7*16 +: 16] == seg0[7], "R8 clamp", longint'(dest0_out[127:112]), longint'(seg0[7]));
    run_op(4'd3, 8'hFF, {N{16'h7777}}, {N{16'h8888}}, 1'b0);
    run_op(4'd8, 8'hA5, {N{16'h3333}}, {N{16'h4444}}, 1'b1);

    for (int t = 0; t < 150; t++) begin
      for (int i = 0; i < N; i++) begin seg0[i] = 16'($urandom); seg1[i] = 16'($urandom); end
      for (int w = 0; w < N; w++) begin a0[w*16 +: 16] = 16'($urandom); a1[w*16 +: 16] = 16'($urandom); end
      run_op(4'($urandom_range(0, 10)), 8'($urandom), a0, a1, ($urandom_range(0, 7) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule